// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache and reacts to its misses. Every miss is first looked up in a small set of stream buffers. Each buffer is a short FIFO of upcoming sequential block addresses together with their data. If the oldest entry of some buffer holds the missing block, that data is handed back to the cache and no memory access is made for it. The freed slot is then reused for the next block in the sequence, so a buffer keeps running ahead of a sequential access pattern.

When no buffer holds the block, the block forwards the miss to memory as a demand fetch and returns that data to the cache. At the same time it takes over the least recently used buffer. That buffer is emptied and refilled with prefetches of the blocks that follow the missing one. The prefetched blocks never enter the cache directly; they wait in the buffer until the cache asks for them.

Demand fetches and prefetches share one memory request port, and a demand fetch always goes first. Memory responses carry their block address, so a response that arrives after its buffer was reused is simply dropped.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, no buffer holds any block, `miss_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first miss after any reset is therefore answered from memory (`resp_from_stream` = 0).
- R2: A miss that hits no buffer is sent to memory as a request for the missing block address. It is answered with `resp_from_stream` = 0 and with the data memory returned for that address.
- R3: A miss that hits no buffer takes over one buffer and fills it with the DEPTH block addresses that follow the miss address. A later miss at the miss address plus one is answered with `resp_from_stream` = 1.
- R4: Only the oldest (head) entry of each buffer is compared. A miss whose address sits deeper in a buffer is treated as a miss in all buffers.
- R5: A head hit returns the head's data, removes the head, and queues a prefetch for the head address plus DEPTH. A run of consecutive addresses therefore keeps hitting the same buffer.
- R6: A head hit whose data is already present raises `resp_valid` in the cycle right after the miss is accepted.
- R7: A head hit whose data is still outstanding holds the response back until that data arrives. No second memory request is made for the block.
- R8: A demand fetch is presented on the memory port in the cycle after the miss is accepted, ahead of any waiting prefetch.
- R9: The buffer taken over on a miss in all buffers is the least recently used one, where both a hit and a takeover count as a use. After reset, buffer NUM_STREAMS-1 is the least recent and buffer 0 the most recent. When two heads match, the lower-numbered buffer serves the miss.
- R10: A miss is accepted only when `miss_valid` and `miss_ready` are both 1. `miss_ready` stays 0 from the acceptance of a miss until the cycle its response is given, unless that response is given one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache reports a miss |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| resp_valid | output | 1 | One-cycle strobe carrying the block for the accepted miss |
| resp_from_stream | output | 1 | 1: served from a stream buffer, 0: fetched from memory |
| resp_data | output | DATA_W | Block data |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_resp_valid | input | 1 | Memory returns a block |
| mem_resp_addr | input | ADDR_W | Address of the returned block |
| mem_resp_data | input | DATA_W | Returned data |

## Verification
A wrong head pointer or a wrong entry address shows up as a wrong `resp_from_stream` flag or wrong data on the very next miss that touches that buffer. Corrupted recency state stays hidden until the next miss in all buffers takes over a buffer. Its effect appears only a few misses later, when a stream that should have survived is served from memory. A stuck pending flag shows as a response that never comes, and a lost priority shows as a demand request that appears a cycle late. The bench compares every response against a model of buffer heads and recency, and it times responses against a memory with a fixed latency.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT_BUF,
    SEQ_DEM_REQ,
    SEQ_DEM_WAIT
  } seq_state_e;
endpackage

// File: rtl/spf_stream_buf.sv
// One stream buffer: a circular FIFO that always holds DEPTH consecutive
// block addresses once it has been allocated.
module spf_stream_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_base,
  input  logic              pop_en,
  input  logic              issue_en,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              live,
  output logic [ADDR_W-1:0] head_addr,
  output logic              head_wait,
  output logic [DATA_W-1:0] head_data,
  output logic              want_issue,
  output logic [ADDR_W-1:0] want_addr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DEPTH);
  localparam logic [PTR_W-1:0]  LAST = PTR_W'(DEPTH - 1);

  logic              live_q, live_n;
  logic [PTR_W-1:0]  head_q, head_n;
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [ADDR_W-1:0] tag_n [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DATA_W-1:0] dat_n [DEPTH];
  logic [DEPTH-1:0]  wait_q, wait_n;
  logic [DEPTH-1:0]  sent_q, sent_n;
  logic [PTR_W-1:0]  want_slot;

  // oldest waiting entry that has not been requested yet
  always_comb begin
    want_issue = 1'b0;
    want_slot  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      int j;
      j = int'(head_q) + i;
      if (j >= DEPTH) j = j - DEPTH;
      if (live_q && wait_q[j] && !sent_q[j]) begin
        want_issue = 1'b1;
        want_slot  = PTR_W'(j);
      end
    end
  end

  assign want_addr = tag_q[want_slot];
  assign live      = live_q;
  assign head_addr = tag_q[head_q];
  assign head_wait = wait_q[head_q];
  assign head_data = dat_q[head_q];

  always_comb begin
    live_n = live_q;
    head_n = head_q;
    tag_n  = tag_q;
    dat_n  = dat_q;
    wait_n = wait_q;
    sent_n = sent_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (fill_valid && wait_q[i] && tag_q[i] == fill_addr) begin
        dat_n[i]  = fill_data;
        wait_n[i] = 1'b0;
      end
    end
    if (issue_en) sent_n[want_slot] = 1'b1;
    if (pop_en) begin
      tag_n[head_q]  = tag_q[head_q] + STEP;
      wait_n[head_q] = 1'b1;
      sent_n[head_q] = 1'b0;
      head_n = (head_q == LAST) ? '0 : head_q + 1'b1;
    end
    if (alloc_en) begin
      live_n = 1'b1;
      head_n = '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_n[i]  = alloc_base + ADDR_W'(i);
        wait_n[i] = 1'b1;
        sent_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      head_q <= '0;
      wait_q <= '0;
      sent_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      live_q <= live_n;
      head_q <= head_n;
      wait_q <= wait_n;
      sent_q <= sent_n;
      tag_q  <= tag_n;
      dat_q  <= dat_n;
    end
  end
endmodule

// File: rtl/spf_lru.sv
// Recency ranks: 0 = most recent, N-1 = least recent.
module spf_lru #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_n [N];

  always_comb begin
    age_n = age_q;
    if (touch_en) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_idx) age_n[j] = '0;
        else if (age_q[j] < age_q[touch_idx]) age_n[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int j = 0; j < N; j++) begin
      if (age_q[j] == IDX_W'(N - 1)) victim = IDX_W'(j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) age_q[j] <= IDX_W'(j);
    end else begin
      age_q <= age_n;
    end
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              resp_valid,
  output logic              resp_from_stream,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [ADDR_W-1:0] mem_resp_addr,
  input  logic [DATA_W-1:0] mem_resp_data
);
  import spf_pkg::*;
  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  logic [NUM_STREAMS-1:0] s_live, s_head_wait, s_want;
  logic [NUM_STREAMS-1:0] s_alloc, s_pop, s_issue;
  logic [ADDR_W-1:0]      s_head_addr [NUM_STREAMS];
  logic [ADDR_W-1:0]      s_want_addr [NUM_STREAMS];
  logic [DATA_W-1:0]      s_head_data [NUM_STREAMS];
  logic [ADDR_W-1:0]      alloc_base;

  seq_state_e        state_q, state_n;
  logic [SIDX_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] dem_q, dem_n;
  logic              resp_valid_q, resp_from_q;
  logic [DATA_W-1:0] resp_data_q;
  logic              load, load_from;
  logic [DATA_W-1:0] load_data;

  logic              hit_any, hit_pending, pf_any, dem_active, touch_en;
  logic [SIDX_W-1:0] hit_idx, pf_idx, touch_idx, victim;

  assign alloc_base = miss_addr + ADDR_W'(1);

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_buf
    spf_stream_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(s_alloc[g]), .alloc_base(alloc_base),
      .pop_en(s_pop[g]), .issue_en(s_issue[g]),
      .fill_valid(mem_resp_valid), .fill_addr(mem_resp_addr), .fill_data(mem_resp_data),
      .live(s_live[g]), .head_addr(s_head_addr[g]), .head_wait(s_head_wait[g]),
      .head_data(s_head_data[g]), .want_issue(s_want[g]), .want_addr(s_want_addr[g])
    );
  end

  spf_lru #(.N(NUM_STREAMS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx), .victim(victim)
  );

  // head lookup and prefetch pick: the lowest index wins
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    pf_any  = 1'b0;
    pf_idx  = '0;
    for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
      if (s_live[s] && s_head_addr[s] == miss_addr) begin
        hit_any = 1'b1;
        hit_idx = SIDX_W'(s);
      end
      if (s_want[s]) begin
        pf_any = 1'b1;
        pf_idx = SIDX_W'(s);
      end
    end
  end
  assign hit_pending = s_head_wait[hit_idx];

  // memory port: a demand fetch blocks all prefetches
  assign dem_active    = (state_q == SEQ_DEM_REQ);
  assign mem_req_valid = dem_active || pf_any;
  assign mem_req_addr  = dem_active ? dem_q : s_want_addr[pf_idx];
  always_comb begin
    s_issue = '0;
    if (!dem_active && pf_any && mem_req_ready) s_issue[pf_idx] = 1'b1;
  end

  assign miss_ready = (state_q == SEQ_IDLE);

  always_comb begin
    state_n   = state_q;
    cur_n     = cur_q;
    dem_n     = dem_q;
    load      = 1'b0;
    load_from = 1'b0;
    load_data = s_head_data[cur_q];
    s_alloc   = '0;
    s_pop     = '0;
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    unique case (state_q)
      SEQ_IDLE: if (miss_valid) begin
        touch_en = 1'b1;
        if (hit_any) begin
          if (!hit_pending) begin
            s_pop[hit_idx] = 1'b1;
            load      = 1'b1;
            load_from = 1'b1;
            load_data = s_head_data[hit_idx];
          end else begin
            cur_n   = hit_idx;
            state_n = SEQ_WAIT_BUF;
          end
        end else begin
          touch_idx       = victim;
          s_alloc[victim] = 1'b1;
          dem_n           = miss_addr;
          state_n         = SEQ_DEM_REQ;
        end
      end
      SEQ_WAIT_BUF: if (!s_head_wait[cur_q]) begin
        s_pop[cur_q] = 1'b1;
        load      = 1'b1;
        load_from = 1'b1;
        state_n   = SEQ_IDLE;
      end
      SEQ_DEM_REQ: if (mem_req_ready) state_n = SEQ_DEM_WAIT;
      SEQ_DEM_WAIT: if (mem_resp_valid && mem_resp_addr == dem_q) begin
        load      = 1'b1;
        load_data = mem_resp_data;
        state_n   = SEQ_IDLE;
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      cur_q        <= '0;
      dem_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_from_q  <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      state_q      <= state_n;
      cur_q        <= cur_n;
      dem_q        <= dem_n;
      resp_valid_q <= load;
      if (load) begin
        resp_from_q <= load_from;
        resp_data_q <= load_data;
      end
    end
  end

  assign resp_valid       = resp_valid_q;
  assign resp_from_stream = resp_from_q;
  assign resp_data        = resp_data_q;
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              resp_valid,
  input logic              resp_from_stream,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              hit_any,
  input logic              hit_pending
);
  logic acc;
  assign acc = miss_valid && miss_ready;

  AST_READY_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit_any && !hit_pending) |=> (resp_valid && resp_from_stream)); // R6

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit_any && hit_pending) |=> (!resp_valid && !miss_ready)); // R7

  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit_any) |=> (mem_req_valid && mem_req_addr == $past(miss_addr))); // R8

  AST_DEMAND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit_any) |=> (!miss_ready && !resp_valid)); // R10
endmodule

bind stream_prefetcher spf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_addr(miss_addr), .resp_valid(resp_valid), .resp_from_stream(resp_from_stream),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .hit_any(hit_any), .hit_pending(hit_pending)
);

// File: tb/stream_prefetcher_bench.sv
`timescale 1ns/1ps
module stream_prefetcher_bench;
  localparam int AW = 16, DW = 32, NS = 4, DEP = 2, LAT = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, miss_valid, miss_ready, resp_valid, resp_from_stream;
  logic [AW-1:0] miss_addr, mem_req_addr, mem_resp_addr;
  logic [DW-1:0] resp_data, mem_resp_data;
  logic mem_req_valid, mem_req_ready, mem_resp_valid;

  stream_prefetcher #(.ADDR_W(AW), .DATA_W(DW), .NUM_STREAMS(NS), .DEPTH(DEP)) u_stream_prefetcher (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .resp_valid(resp_valid), .resp_from_stream(resp_from_stream),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_addr(mem_resp_addr), .mem_resp_data(mem_resp_data)
  );

  int n_checks = 0, n_fail = 0;
  longint cyc = 0;
  bit mem_block = 0, rand_ready = 0;
  logic [AW-1:0] watch_addr = '0;
  int watch_cnt = 0;
  logic [AW-1:0] q_addr[$];
  longint q_due[$];

  // reference model of buffer heads and recency
  bit m_live[NS];
  logic [AW-1:0] m_head[NS];
  int m_age[NS];

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return (DW'(a) * 32'h9E37_79B9) ^ 32'h0BAD_F00D;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_live[i] = 0; m_head[i] = '0; m_age[i] = i;
    end
  endtask

  task automatic model_touch(int s);
    int a;
    a = m_age[s];
    for (int j = 0; j < NS; j++) begin
      if (j == s) m_age[j] = 0;
      else if (m_age[j] < a) m_age[j]++;
    end
  endtask

  // memory: fixed latency, in order, one response per cycle
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (!rst_n) begin
      q_addr.delete(); q_due.delete();
      mem_resp_valid = 0; mem_req_ready = 0;
      mem_resp_addr = '0; mem_resp_data = '0;
    end else begin
      if (q_due.size() > 0 && q_due[0] <= cyc) begin
        mem_resp_valid = 1;
        mem_resp_addr  = q_addr[0];
        mem_resp_data  = mem_word(q_addr[0]);
        void'(q_addr.pop_front()); void'(q_due.pop_front());
      end else mem_resp_valid = 0;
      rdy = !mem_block && (!rand_ready || ($urandom % 4) != 0);
      mem_req_ready = rdy;
      if (mem_req_valid && rdy) begin
        q_addr.push_back(mem_req_addr);
        q_due.push_back(cyc + LAT);
        if (mem_req_addr == watch_addr) watch_cnt++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic do_miss(input logic [AW-1:0] a, input string req,
                         output bit fs, output int lat);
    int e, guard;
    bit efs;
    e = -1;
    for (int i = NS - 1; i >= 0; i--) if (m_live[i] && m_head[i] == a) e = i;
    efs = (e >= 0);
    if (efs) begin
      m_head[e] = a + 1'b1; model_touch(e);
    end else begin
      int v;
      v = 0;
      for (int i = 0; i < NS; i++) if (m_age[i] == NS - 1) v = i;
      m_live[v] = 1; m_head[v] = a + 1'b1; model_touch(v);
    end
    watch_addr = a; watch_cnt = 0;
    @(negedge clk);
    miss_valid = 1; miss_addr = a;
    while (!miss_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0;
    lat = 1; guard = 0;
    while (!resp_valid && guard < 1000) begin
      @(negedge clk); lat++; guard++;
    end
    fs = resp_from_stream;
    check(resp_valid, req, "response missing", resp_valid, 1);
    check(fs == efs, req, "source flag", fs, efs);
    check(resp_data == mem_word(a), efs ? "R5" : "R2", "data", resp_data, mem_word(a));
    if (efs) check(watch_cnt <= 1, "R7", "requests for block", watch_cnt, 1);
    else     check(watch_cnt >= 1, "R2", "demand requests", watch_cnt, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit fs;
    int lat;
    logic [AW-1:0] cur [6];
    void'($urandom(32'd4711));
    miss_valid = 0; miss_addr = '0;
    do_reset();

    // R1: reset state
    check(miss_ready == 1, "R1", "miss_ready after reset", miss_ready, 1);
    check(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
    check(mem_req_valid == 0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    repeat (5) @(negedge clk);

    // R2, R8: demand fetch, presented before prefetches
    do_miss(16'h0100, "R1", fs, lat);
    check(fs == 0, "R2", "first miss from memory", fs, 0);
    check(lat == LAT + 2, "R8", "demand latency", lat, LAT + 2);
    repeat (30) @(negedge clk);

    // R3, R6: successor served from buffer one cycle after acceptance
    do_miss(16'h0101, "R3", fs, lat);
    check(fs == 1, "R3", "successor hit", fs, 1);
    check(lat == 1, "R6", "ready hit latency", lat, 1);

    // R4: a deeper entry does not hit
    do_miss(16'h0103, "R4", fs, lat);
    check(fs == 0, "R4", "non-head entry", fs, 0);
    repeat (30) @(negedge clk);

    // R5: sequential run keeps hitting
    for (int k = 0; k < 12; k++) begin
      do_miss(16'h0104 + 16'(k), "R5", fs, lat);
      check(fs == 1, "R5", "sequential run", fs, 1);
    end
    repeat (30) @(negedge clk);

    // R7, R10: pending head waits for its single prefetch
    do_miss(16'h0200, "R2", fs, lat);
    repeat (30) @(negedge clk);
    mem_block = 1;
    do_miss(16'h0201, "R6", fs, lat);
    check(lat == 1, "R6", "ready hit latency", lat, 1);
    do_miss(16'h0202, "R6", fs, lat);
    check(lat == 1, "R6", "ready hit latency", lat, 1);
    fork
      do_miss(16'h0203, "R7", fs, lat);
      begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
          check(resp_valid == 0, "R7", "early response", resp_valid, 0);
          check(miss_ready == 0, "R10", "ready while busy", miss_ready, 0);
          @(negedge clk);
        end
        mem_block = 0;
      end
    join
    check(fs == 1, "R7", "pending head served", fs, 1);
    check(lat > 12, "R7", "waited for data", lat, 13);
    check(watch_cnt == 1, "R7", "single request", watch_cnt, 1);

    // R9: least recently used buffer is replaced
    do_reset();
    do_miss(16'h1000, "R9", fs, lat);
    do_miss(16'h2000, "R9", fs, lat);
    do_miss(16'h3000, "R9", fs, lat);
    do_miss(16'h4000, "R9", fs, lat);
    repeat (30) @(negedge clk);
    do_miss(16'h1001, "R9", fs, lat);
    check(fs == 1, "R9", "refreshed stream", fs, 1);
    do_miss(16'h5000, "R9", fs, lat);
    do_miss(16'h3001, "R9", fs, lat);
    check(fs == 1, "R9", "kept stream", fs, 1);
    do_miss(16'h2001, "R9", fs, lat);
    check(fs == 0, "R9", "evicted stream", fs, 0);

    // R1: reset drops every buffer
    repeat (30) @(negedge clk);
    do_reset();
    do_miss(16'h3002, "R1", fs, lat);
    check(fs == 0, "R1", "buffer after reset", fs, 0);

    // random mix of interleaved sequential streams
    rand_ready = 1;
    for (int k = 0; k < 6; k++) cur[k] = 16'($urandom);
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom % 6;
      if ($urandom % 10 == 0) cur[k] = 16'($urandom);
      do_miss(cur[k], "R3", fs, lat);
      cur[k] = cur[k] + (($urandom % 8 == 0) ? 16'd2 : 16'd1);
      if ($urandom % 5 == 0) repeat ($urandom % 8) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule